// File: doc/BRIEF.md
# Bidirectional FIFO Pair with Routed Status Flags

This block carries data both ways between two 18-bit sides. One synchronous FIFO moves words from side A to side B, and a second FIFO moves words from side B back to side A. Each data path is a valid/ready stream. A producer may hold `*_in_valid` high for as long as it likes, and a word transfers only on a rising clock edge where valid and ready are both high. A FIFO lowers its input ready while it holds `DEPTH` words. A FIFO raises its output valid whenever it holds at least one word, and the head word sits stable on the output data until it is taken. A consumer applies back-pressure by holding its ready low, and no data is lost when it does.

All control comes from side A through a plain register port. Writes take effect on the clock edge where `cfg_we` is high, and reads return data combinationally from `cfg_addr`. Through this port side A can:
- clear either FIFO,
- mark and rewind pointers so that side B can read data again or overwrite data it has written,
- set the almost-empty and almost-full thresholds of each FIFO,
- choose which four of the eight internal flags drive the four flag pins,
- leave a 9-bit message in a one-entry mailbox that side B reads without going through either FIFO.

`DEPTH` must be a power of two.

Top module: `duplex_fifo_ctrl`

## Requirements
- R1: Words accepted at `a_in` leave at `b_out` in the same order, and words accepted at `b_in` leave at `a_out` in the same order. Each accepted word raises the FIFO's occupancy by one, unless that same FIFO also hands out a word in the same cycle.
- R2: A FIFO holding `DEPTH` words lowers its input ready, and a word offered while it is full is not stored. An empty FIFO lowers its output valid, and a ready pulse while it is empty takes nothing and leaves the pointers unchanged.
- R3: The status register at address 1 reads back the flags as follows: bit 0 is A-to-B empty, bit 1 is A-to-B almost-empty, bit 2 is A-to-B almost-full, bit 3 is A-to-B full. Bits 4 to 7 hold the same four flags for the B-to-A FIFO. Bit 8 is mailbox-valid. A FIFO's empty flag is high exactly when its output valid is low.
- R4: Almost-empty is high while occupancy is at or below the threshold. Almost-full is high while free space is at or below the threshold. The thresholds are at address 2 (A-to-B almost-empty), address 3 (A-to-B almost-full), address 4 (B-to-A almost-empty) and address 5 (B-to-A almost-full), and each resets to 0.
- R5: The routing register at address 6 holds four 3-bit codes. Bits [3k+2:3k] choose the flag that drives `flag_pins[k]`. Codes 0 to 3 select A-to-B empty, almost-empty, almost-full and full. Codes 4 to 7 select the same four flags of the B-to-A FIFO. The register resets to codes 0, 3, 4 and 7 for pins 0 to 3.
- R6: After reset, both FIFOs are empty, the mailbox is invalid, the status register reads 0x033 and `flag_pins` reads 4'b0101.
- R7: A write to address 7 stores `cfg_wdata[8:0]` in the mailbox and raises `b_byp_valid`, and address 7 reads the stored message back. A `b_byp_rd` pulse clears `b_byp_valid`. If a write to address 7 arrives in the same cycle as `b_byp_rd`, the mailbox stays valid.
- R8: The command register at address 0 is made of one-cycle strobes and always reads 0. Bit 0 empties the A-to-B FIFO and bit 1 empties the B-to-A FIFO. A clear takes priority over a rewind of the same FIFO given in the same write.
- R9: Command bit 2 saves the A-to-B read position and bit 3 returns to the saved position, so side B reads again the words it took after the mark.
- R10: Command bit 4 saves the B-to-A write position and bit 5 returns to the saved position, so words written after the mark are dropped and the next writes overwrite them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in_valid | input | 1 | Side A offers a word for side B |
| a_in_ready | output | 1 | A-to-B FIFO can accept a word |
| a_in_data | input | DW | Word from side A |
| b_out_valid | output | 1 | A-to-B head word is available |
| b_out_ready | input | 1 | Side B takes the head word |
| b_out_data | output | DW | A-to-B head word |
| b_in_valid | input | 1 | Side B offers a word for side A |
| b_in_ready | output | 1 | B-to-A FIFO can accept a word |
| b_in_data | input | DW | Word from side B |
| a_out_valid | output | 1 | B-to-A head word is available |
| a_out_ready | input | 1 | Side A takes the head word |
| a_out_data | output | DW | B-to-A head word |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data |
| b_byp_rd | input | 1 | Side B takes the mailbox message |
| b_byp_data | output | BW | Mailbox message |
| b_byp_valid | output | 1 | Mailbox holds an unread message |
| flag_pins | output | 4 | Routed flag outputs |

## Verification
The assertions take for granted that a rewind never moves a pointer past the other pointer of the same FIFO, and that the slots being replayed after a mark have not been overwritten. Under that assumption, occupancy stays between zero and `DEPTH`, and the empty/full and almost flags stay consistent with the stream handshakes. The stimulus places each mark only while the FIFO holds the words that will be replayed. It writes no new words between a reread mark and its rewind, and it rewinds a write pointer only while the read pointer is still behind the mark. The push-while-full and pop-while-empty cases are driven with command writes held idle, so that the checks that occupancy does not change are not disturbed by a clear.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  // register addresses on the control side
  localparam logic [3:0] REG_CMD   = 4'd0;
  localparam logic [3:0] REG_STAT  = 4'd1;
  localparam logic [3:0] REG_AE_AB = 4'd2;
  localparam logic [3:0] REG_AF_AB = 4'd3;
  localparam logic [3:0] REG_AE_BA = 4'd4;
  localparam logic [3:0] REG_AF_BA = 4'd5;
  localparam logic [3:0] REG_ROUTE = 4'd6;
  localparam logic [3:0] REG_BYP   = 4'd7;

  // command strobe bit positions
  localparam int CMD_CLR_AB  = 0;
  localparam int CMD_CLR_BA  = 1;
  localparam int CMD_MARK_AB = 2;
  localparam int CMD_REW_AB  = 3;
  localparam int CMD_MARK_BA = 4;
  localparam int CMD_REW_BA  = 5;

  localparam int N_PINS  = 4;
  localparam int N_FLAGS = 8;
  localparam int SEL_W   = $clog2(N_FLAGS);
  localparam int ROUTE_W = N_PINS * SEL_W;

  localparam logic [ROUTE_W-1:0] ROUTE_RST = {3'd7, 3'd4, 3'd3, 3'd0};

  // bit 0 is empty, so a code's low two bits index this struct
  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } fifo_flags_t;
endpackage

// File: rtl/dfc_fifo.sv
module dfc_fifo #(
  parameter int DW        = 18,
  parameter int DEPTH     = 1024,
  parameter bit REWIND_WR = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mark,
  input  logic          rewind,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wptr, rptr, mark_q;
  logic          push, pop, wr_en;

  assign count     = wptr - rptr;
  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rptr[AW-1:0]];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  generate
    if (REWIND_WR) begin : g_rewrite
      // mark and rewind act on the write pointer
      assign wr_en = push && !clr && !rewind;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wptr <= '0; rptr <= '0; mark_q <= '0;
        end else if (clr) begin
          wptr <= '0; rptr <= '0; mark_q <= '0;
        end else begin
          if (mark)        mark_q <= wptr;
          if (rewind)      wptr   <= mark_q;
          else if (push)   wptr   <= wptr + CW'(1);
          if (pop)         rptr   <= rptr + CW'(1);
        end
      end
    end else begin : g_reread
      // mark and rewind act on the read pointer
      assign wr_en = push && !clr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wptr <= '0; rptr <= '0; mark_q <= '0;
        end else if (clr) begin
          wptr <= '0; rptr <= '0; mark_q <= '0;
        end else begin
          if (mark)        mark_q <= rptr;
          if (rewind)      rptr   <= mark_q;
          else if (pop)    rptr   <= rptr + CW'(1);
          if (push)        wptr   <= wptr + CW'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= in_data;
  end
endmodule

// File: rtl/dfc_flags.sv
module dfc_flags
  import dfc_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] ae_off,
  input  logic [CW-1:0] af_off,
  output fifo_flags_t   flags
);
  logic [CW-1:0] free_slots;

  always_comb begin
    free_slots   = CW'(DEPTH) - count;
    flags.empty  = (count == '0);
    flags.full   = (count == CW'(DEPTH));
    flags.aempty = (count <= ae_off);
    flags.afull  = (free_slots <= af_off);
  end
endmodule

// File: rtl/dfc_route.sv
module dfc_route #(
  parameter int NP = 4,
  parameter int NF = 8,
  localparam int SW = $clog2(NF)
) (
  input  logic [NF-1:0]    flags,
  input  logic [NP*SW-1:0] sel,
  output logic [NP-1:0]    pins
);
  for (genvar k = 0; k < NP; k++) begin : g_pin
    assign pins[k] = flags[sel[k*SW +: SW]];
  end
endmodule

// File: rtl/dfc_regs.sv
module dfc_regs
  import dfc_pkg::*;
#(
  parameter int DW = 18,
  parameter int CW = 11,
  parameter int BW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [3:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [N_FLAGS-1:0] flag_vec,
  input  logic               byp_rd,
  output logic               clr_ab,
  output logic               clr_ba,
  output logic               mark_ab,
  output logic               rew_ab,
  output logic               mark_ba,
  output logic               rew_ba,
  output logic [CW-1:0]      ae_ab,
  output logic [CW-1:0]      af_ab,
  output logic [CW-1:0]      ae_ba,
  output logic [CW-1:0]      af_ba,
  output logic [ROUTE_W-1:0] route,
  output logic [BW-1:0]      byp_data,
  output logic               byp_valid
);
  logic cmd_we, byp_we;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign cmd_we  = we && (addr == REG_CMD);
  assign byp_we  = we && (addr == REG_BYP);

  // one-cycle strobes straight from the write
  assign clr_ab  = cmd_we && wdata[CMD_CLR_AB];
  assign clr_ba  = cmd_we && wdata[CMD_CLR_BA];
  assign mark_ab = cmd_we && wdata[CMD_MARK_AB];
  assign rew_ab  = cmd_we && wdata[CMD_REW_AB];
  assign mark_ba = cmd_we && wdata[CMD_MARK_BA];
  assign rew_ba  = cmd_we && wdata[CMD_REW_BA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ab    <= '0;
      af_ab    <= '0;
      ae_ba    <= '0;
      af_ba    <= '0;
      route    <= ROUTE_RST;
      byp_data <= '0;
    end else if (we) begin
      case (addr)
        REG_AE_AB: ae_ab    <= wdata[CW-1:0];
        REG_AF_AB: af_ab    <= wdata[CW-1:0];
        REG_AE_BA: ae_ba    <= wdata[CW-1:0];
        REG_AF_BA: af_ba    <= wdata[CW-1:0];
        REG_ROUTE: route    <= wdata[ROUTE_W-1:0];
        REG_BYP:   byp_data <= wdata[BW-1:0];
        default: ;
      endcase
    end
  end

  // a new message wins over a take in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byp_valid <= 1'b0;
    else if (byp_we) byp_valid <= 1'b1;
    else if (byp_rd) byp_valid <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_STAT:  rdata = DW'({byp_valid, flag_vec});
      REG_AE_AB: rdata = DW'(ae_ab);
      REG_AF_AB: rdata = DW'(af_ab);
      REG_AE_BA: rdata = DW'(ae_ba);
      REG_AF_BA: rdata = DW'(af_ba);
      REG_ROUTE: rdata = DW'(route);
      REG_BYP:   rdata = DW'(byp_data);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/duplex_fifo_ctrl.sv
module duplex_fifo_ctrl
  import dfc_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 1024,
  parameter int BW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_in_valid,
  output logic          a_in_ready,
  input  logic [DW-1:0] a_in_data,
  output logic          b_out_valid,
  input  logic          b_out_ready,
  output logic [DW-1:0] b_out_data,
  input  logic          b_in_valid,
  output logic          b_in_ready,
  input  logic [DW-1:0] b_in_data,
  output logic          a_out_valid,
  input  logic          a_out_ready,
  output logic [DW-1:0] a_out_data,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          b_byp_rd,
  output logic [BW-1:0] b_byp_data,
  output logic          b_byp_valid,
  output logic [3:0]    flag_pins
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]      ab_count, ba_count;
  logic [CW-1:0]      ae_ab, af_ab, ae_ba, af_ba;
  logic [ROUTE_W-1:0] route;
  fifo_flags_t        ab_flags, ba_flags;
  logic               clr_ab, clr_ba, mark_ab, rew_ab, mark_ba, rew_ba;

  dfc_fifo #(.DW(DW), .DEPTH(DEPTH), .REWIND_WR(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n), .clr(clr_ab), .mark(mark_ab), .rewind(rew_ab),
    .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data),
    .count(ab_count)
  );

  dfc_fifo #(.DW(DW), .DEPTH(DEPTH), .REWIND_WR(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n), .clr(clr_ba), .mark(mark_ba), .rewind(rew_ba),
    .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data),
    .count(ba_count)
  );

  dfc_flags #(.DEPTH(DEPTH)) u_ab_flags (
    .count(ab_count), .ae_off(ae_ab), .af_off(af_ab), .flags(ab_flags)
  );

  dfc_flags #(.DEPTH(DEPTH)) u_ba_flags (
    .count(ba_count), .ae_off(ae_ba), .af_off(af_ba), .flags(ba_flags)
  );

  dfc_regs #(.DW(DW), .CW(CW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .flag_vec({ba_flags, ab_flags}), .byp_rd(b_byp_rd),
    .clr_ab(clr_ab), .clr_ba(clr_ba), .mark_ab(mark_ab), .rew_ab(rew_ab),
    .mark_ba(mark_ba), .rew_ba(rew_ba),
    .ae_ab(ae_ab), .af_ab(af_ab), .ae_ba(ae_ba), .af_ba(af_ba),
    .route(route), .byp_data(b_byp_data), .byp_valid(b_byp_valid)
  );

  dfc_route #(.NP(N_PINS), .NF(N_FLAGS)) u_route (
    .flags({ba_flags, ab_flags}), .sel(route), .pins(flag_pins)
  );
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_in_valid,
  input logic          a_in_ready,
  input logic          b_out_valid,
  input logic          b_out_ready,
  input logic          b_in_valid,
  input logic          b_in_ready,
  input logic          a_out_valid,
  input logic          a_out_ready,
  input logic          cfg_we,
  input logic [3:0]    cfg_addr,
  input logic          cfg_clr_ab,
  input logic          b_byp_rd,
  input logic          b_byp_valid,
  input logic [CW-1:0] ab_count,
  input logic [CW-1:0] ba_count,
  input logic [3:0]    ab_flags,
  input logic [3:0]    ba_flags
);
  logic cmd_wr, byp_wr;
  assign cmd_wr = cfg_we && (cfg_addr == 4'd0);
  assign byp_wr = cfg_we && (cfg_addr == 4'd7);

  // R1: a lone accepted word raises occupancy by one
  assert_push_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in_valid && a_in_ready && !(b_out_valid && b_out_ready) && !cmd_wr)
      |=> ab_count == $past(ab_count) + CW'(1));

  assert_push_step_ba_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_in_valid && b_in_ready && !(a_out_valid && a_out_ready) && !cmd_wr)
      |=> ba_count == $past(ba_count) + CW'(1));

  // R2: an offer to a full FIFO with nothing leaving changes nothing
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in_valid && !a_in_ready && !b_out_ready && !cmd_wr) |=> $stable(ab_count));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_count <= CW'(DEPTH)) && (ba_count <= CW'(DEPTH)));

  // R3: empty flag and output valid come from separate logic and must agree
  assert_empty_matches_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_flags[0] != b_out_valid) && (ba_flags[0] != a_out_valid));

  // R4: empty implies almost-empty, full implies almost-full
  assert_edge_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_flags[0] |-> ab_flags[1]) and (ab_flags[3] |-> ab_flags[2]) and
    (ba_flags[0] |-> ba_flags[1]) and (ba_flags[3] |-> ba_flags[2]));

  // R7: mailbox set and take
  assert_mailbox_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byp_wr |=> b_byp_valid);

  assert_mailbox_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_byp_rd && !byp_wr) |=> !b_byp_valid);

  // R8: a clear strobe empties the A-to-B FIFO on the next cycle
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr_ab |=> !b_out_valid);
endmodule

bind duplex_fifo_ctrl dfc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_in_valid(a_in_valid), .a_in_ready(a_in_ready),
  .b_out_valid(b_out_valid), .b_out_ready(b_out_ready),
  .b_in_valid(b_in_valid), .b_in_ready(b_in_ready),
  .a_out_valid(a_out_valid), .a_out_ready(a_out_ready),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_clr_ab(clr_ab),
  .b_byp_rd(b_byp_rd), .b_byp_valid(b_byp_valid),
  .ab_count(ab_count), .ba_count(ba_count),
  .ab_flags(ab_flags), .ba_flags(ba_flags)
);

// File: tb/duplex_fifo_ctrl_tb.sv
module duplex_fifo_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int DEPTH = 16;
  localparam int BW = 9;

  localparam logic [2:0] OP_REGW = 3'd0, OP_REGR = 3'd1, OP_APUSH = 3'd2,
                         OP_BPOP = 3'd3, OP_BPUSH = 3'd4, OP_APOP = 3'd5,
                         OP_PINS = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [3:0]  addr;
    logic [17:0] val;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{OP_REGR,  4'd6, 4'd1, 18'h00033},  // R6 reset status
    '{OP_PINS,  4'd6, 4'd0, 18'h00005},  // R6 reset pins
    '{OP_REGW,  4'd4, 4'd2, 18'd3},      // R4 A-to-B almost-empty threshold 3
    '{OP_REGW,  4'd4, 4'd3, 18'd2},      // R4 A-to-B almost-full threshold 2
    '{OP_REGR,  4'd4, 4'd2, 18'd3},      // R4 readback
    '{OP_APUSH, 4'd1, 4'd0, 18'h1A001},  // R1
    '{OP_APUSH, 4'd1, 4'd0, 18'h1A002},
    '{OP_APUSH, 4'd1, 4'd0, 18'h1A003},
    '{OP_REGR,  4'd3, 4'd1, 18'h00032},  // R3 R4 occupancy 3
    '{OP_APUSH, 4'd1, 4'd0, 18'h1A004},
    '{OP_REGR,  4'd4, 4'd1, 18'h00030},  // R4 occupancy 4 above threshold
    '{OP_BPOP,  4'd1, 4'd0, 18'h1A001},  // R1 order
    '{OP_BPOP,  4'd1, 4'd0, 18'h1A002},
    '{OP_BPUSH, 4'd1, 4'd0, 18'h2B001},  // R1 other direction
    '{OP_BPUSH, 4'd1, 4'd0, 18'h2B002},
    '{OP_APOP,  4'd1, 4'd0, 18'h2B001},
    '{OP_APOP,  4'd1, 4'd0, 18'h2B002},
    '{OP_REGW,  4'd5, 4'd6, 18'h0010B},  // R5 codes pin0=3 pin1=1 pin2=4 pin3=0
    '{OP_PINS,  4'd5, 4'd0, 18'h00006},  // R5
    '{OP_REGR,  4'd5, 4'd6, 18'h0010B},  // R5 readback
    '{OP_BPOP,  4'd1, 4'd0, 18'h1A003},
    '{OP_BPOP,  4'd1, 4'd0, 18'h1A004},
    '{OP_PINS,  4'd5, 4'd0, 18'h0000E},  // R5 after emptying
    '{OP_REGW,  4'd7, 4'd7, 18'h001A5},  // R7 mailbox write
    '{OP_REGR,  4'd7, 4'd7, 18'h001A5},  // R7 readback
    '{OP_REGR,  4'd7, 4'd1, 18'h00133}   // R7 R3 valid bit 8
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_in_valid = 1'b0, b_out_ready = 1'b0;
  logic          b_in_valid = 1'b0, a_out_ready = 1'b0;
  logic [DW-1:0] a_in_data = '0, b_in_data = '0, cfg_wdata = '0;
  logic          cfg_we = 1'b0, b_byp_rd = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic          a_in_ready, b_out_valid, b_in_ready, a_out_valid, b_byp_valid;
  logic [DW-1:0] b_out_data, a_out_data, cfg_rdata;
  logic [BW-1:0] b_byp_data;
  logic [3:0]    flag_pins;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duplex_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in_valid(a_in_valid), .a_in_ready(a_in_ready), .a_in_data(a_in_data),
    .b_out_valid(b_out_valid), .b_out_ready(b_out_ready), .b_out_data(b_out_data),
    .b_in_valid(b_in_valid), .b_in_ready(b_in_ready), .b_in_data(b_in_data),
    .a_out_valid(a_out_valid), .a_out_ready(a_out_ready), .a_out_data(a_out_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .b_byp_rd(b_byp_rd), .b_byp_data(b_byp_data), .b_byp_valid(b_byp_valid),
    .flag_pins(flag_pins)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic push_a(input logic [DW-1:0] d);
    @(negedge clk);
    a_in_valid = 1'b1; a_in_data = d;
    @(negedge clk);
    a_in_valid = 1'b0;
  endtask

  task automatic push_b(input logic [DW-1:0] d);
    @(negedge clk);
    b_in_valid = 1'b1; b_in_data = d;
    @(negedge clk);
    b_in_valid = 1'b0;
  endtask

  task automatic pop_b(input string tag, input logic [DW-1:0] exp);
    @(negedge clk);
    chk({tag, " b_out_valid"}, b_out_valid, 1);
    chk({tag, " b_out_data"}, b_out_data, exp);
    b_out_ready = 1'b1;
    @(negedge clk);
    b_out_ready = 1'b0;
  endtask

  task automatic pop_a(input string tag, input logic [DW-1:0] exp);
    @(negedge clk);
    chk({tag, " a_out_valid"}, a_out_valid, 1);
    chk({tag, " a_out_data"}, a_out_data, exp);
    a_out_ready = 1'b1;
    @(negedge clk);
    a_out_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] st;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 reset state at the stream ports
    @(negedge clk);
    chk("R6 a_in_ready", a_in_ready, 1);
    chk("R6 b_out_valid", b_out_valid, 0);
    chk("R6 a_out_valid", a_out_valid, 0);
    chk("R6 b_byp_valid", b_byp_valid, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d entry %0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_REGW:  reg_wr(VECS[i].addr, VECS[i].val);
        OP_REGR:  begin reg_rd(VECS[i].addr, st); chk(tag, st, VECS[i].val); end
        OP_APUSH: push_a(VECS[i].val);
        OP_BPUSH: push_b(VECS[i].val);
        OP_BPOP:  pop_b(tag, VECS[i].val);
        OP_APOP:  pop_a(tag, VECS[i].val);
        OP_PINS:  begin @(negedge clk); #1 chk(tag, flag_pins, VECS[i].val[3:0]); end
        default: ;
      endcase
    end

    // R2 and R4: fill A-to-B, watch almost-full at free space 2
    for (int i = 0; i < DEPTH; i++) begin
      push_a(DW'(18'h03000 + i));
      reg_rd(4'd1, st);
      if (i + 1 == DEPTH - 3) chk("R4 almost-full low at free 3", st[2], 0);
      if (i + 1 == DEPTH - 2) chk("R4 almost-full high at free 2", st[2], 1);
    end
    chk("R2 full lowers a_in_ready", a_in_ready, 0);
    reg_rd(4'd1, st);
    chk("R3 full status bit 3", st[3], 1);
    push_a(18'h3FFFF);  // R2 ignored while full
    for (int i = 0; i < DEPTH; i++) pop_b("R2 drain", DW'(18'h03000 + i));
    @(negedge clk);
    chk("R2 offered word not stored", b_out_valid, 0);
    b_out_ready = 1'b1;  // R2 take from empty
    @(negedge clk);
    b_out_ready = 1'b0;
    push_a(18'h00155);
    pop_b("R2 pointers unchanged after empty take", 18'h00155);

    // R4 on the B-to-A FIFO
    reg_wr(4'd4, 18'd1);
    reg_wr(4'd5, 18'd14);
    push_b(18'h00001);
    reg_rd(4'd1, st);
    chk("R4 B-to-A almost-empty at 1", st[5], 1);
    push_b(18'h00002);
    reg_rd(4'd1, st);
    chk("R4 B-to-A almost-empty clear at 2", st[5], 0);
    chk("R4 B-to-A almost-full at free 14", st[6], 1);

    // R8 clear B-to-A, then clear beats rewind on A-to-B
    reg_wr(4'd0, 18'h00002);
    @(negedge clk);
    chk("R8 B-to-A cleared", a_out_valid, 0);
    push_a(18'h00A01); push_a(18'h00A02); push_a(18'h00A03);
    reg_wr(4'd0, 18'h00009);
    @(negedge clk);
    chk("R8 clear wins over rewind", b_out_valid, 0);
    reg_rd(4'd1, st);
    chk("R8 status after clears", st[7:0], 8'h33);
    reg_rd(4'd0, st);
    chk("R8 command reads zero", st, 0);

    // R9 reread
    push_a(18'h00010); push_a(18'h00011); push_a(18'h00012); push_a(18'h00013);
    pop_b("R9 before mark", 18'h00010);
    reg_wr(4'd0, 18'h00004);
    pop_b("R9 first pass", 18'h00011);
    pop_b("R9 first pass", 18'h00012);
    reg_wr(4'd0, 18'h00008);
    pop_b("R9 replay", 18'h00011);
    pop_b("R9 replay", 18'h00012);
    pop_b("R9 replay", 18'h00013);
    @(negedge clk);
    chk("R9 empty after replay", b_out_valid, 0);

    // R10 rewrite
    push_b(18'h00020); push_b(18'h00021);
    reg_wr(4'd0, 18'h00010);
    push_b(18'h00022); push_b(18'h00023);
    reg_wr(4'd0, 18'h00020);
    push_b(18'h00024);
    pop_a("R10 kept", 18'h00020);
    pop_a("R10 kept", 18'h00021);
    pop_a("R10 overwritten slot", 18'h00024);
    @(negedge clk);
    chk("R10 dropped words gone", a_out_valid, 0);

    // R7 mailbox take and same-cycle collision
    @(negedge clk);
    b_byp_rd = 1'b1;
    @(negedge clk);
    b_byp_rd = 1'b0;
    chk("R7 take clears valid", b_byp_valid, 0);
    reg_rd(4'd1, st);
    chk("R7 status bit 8 clear", st[8], 0);
    reg_wr(4'd7, 18'h000C3);
    chk("R7 valid after write", b_byp_valid, 1);
    chk("R7 message data", b_byp_data, 9'h0C3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 18'h0007E; b_byp_rd = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; b_byp_rd = 1'b0;
    chk("R7 write wins over take", b_byp_valid, 1);
    chk("R7 new message", b_byp_data, 9'h07E);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule